// File: doc/BRIEF.md
# Programmable Product-Term Chip-Select Decoder

This block turns the upper address lines, the page-number bits, a dual-purpose A19/chip-select-input pin, a few general-purpose port inputs and the read, write and ALE strobes into a set of select signals. It is an AND-OR array. Each product term holds two configuration words. The care word picks which decoder inputs the term looks at. The match word gives the value each of those inputs must have. Terms feed single-term outputs directly: eight memory-bank selects, an SRAM select, an I/O-port select and three selects that steer the direction of a multiplexed address/data port. They also feed eleven external chip-selects, which OR together four, two or one terms depending on the output.

All decoding is combinational from the inputs. The only clocked logic is the configuration storage, which is loaded through a synchronous address/data/write-enable port. A mode bit decides how the A19/CSI pin is used. It is either an ordinary term input or a chip-select-input control: when driven high, that control turns every output off and raises a power-down flag. The active-low asynchronous reset clears the configuration and holds every output inactive.

Top module: `pt_cs_decoder`

## Requirements
- R1: Bank select b (b = 0..7) is high exactly when product term 27+b is true.
- R2: The SRAM select follows product term 35 and the I/O-port select follows product term 36.
- R3: External select e (e = 0..3) is the OR of terms 4e to 4e+3 before polarity is applied.
- R4: External select e (e = 4..7) is the OR of terms 16+2(e-4) and 17+2(e-4), and selects 8, 9 and 10 follow terms 24, 25 and 26 alone, all before polarity is applied.
- R5: The port-direction selects follow single terms: address/data input direction term 37, address output direction term 38, data output direction term 39.
- R6: The decoder input vector is, from bit 0 upward: upper address (8 bits), page (4), A19/CSI pin (1), general-purpose inputs (4), read, write, ALE. A term is true when every bit set in its care word has the same value in the input vector as in its match word. A term whose care word is zero is never true.
- R7: Each external select output equals its raw OR value XOR its polarity bit, so a polarity bit of 1 makes that output active low. No other output has a polarity bit.
- R8: When the mode bit is 1 and the A19/CSI pin is high, every internal select is 0, each external select sits at its polarity bit, and the power-down output is 1.
- R9: When the mode bit is 0, the power-down output is 0 and the A19/CSI pin acts as an ordinary term input.
- R10: While rst_ni is low, every output is 0. The reset clears all care words, match words, polarity bits and the mode bit, and it takes effect without waiting for a clock edge.
- R11: A configuration write takes effect on the rising clock edge where the write enable is high. The address map is: care word of term k at address 2k, match word at 2k+1, polarity bits at address 80, mode bit at address 81 (data bit 0). Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_addr_i | input | 7 | Configuration word address |
| cfg_data_i | input | 20 | Configuration write data |
| addr_hi_i | input | 8 | Upper address lines 11 to 18 |
| page_i | input | 4 | Page-number bits |
| a19_csi_i | input | 1 | A19 address input or chip-select-input control |
| gp_i | input | 4 | General-purpose port inputs |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| ale_i | input | 1 | Address latch enable |
| bank_sel_o | output | 8 | Memory-bank selects |
| sram_sel_o | output | 1 | SRAM select |
| io_sel_o | output | 1 | I/O-port select |
| ad_in_sel_o | output | 1 | Address/data port input-direction select |
| ad_addr_out_sel_o | output | 1 | Address/data port address-output select |
| ad_data_out_sel_o | output | 1 | Address/data port data-output select |
| ext_cs_o | output | 11 | External chip-selects after polarity |
| pwr_down_o | output | 1 | Power-down indication in chip-select-input mode |

## Verification
The hardest case to reach from the ports is a term with every care bit set. It fires on exactly one of about a million input vectors, so a hashed sweep will almost never hit it. The bench therefore programs a full-care term to a chosen vector, drives that exact vector, and then drives a vector one bit away. The other cases that need deliberate setup are the chip-select-input gating with a non-zero polarity word and an asynchronous reset that arrives while terms are firing. The bench reaches them by loading a complete configuration first and then sweeping thousands of hashed vectors through both settings of the mode bit.

// File: rtl/pt_pkg.sv
package pt_pkg;
  localparam int ADDR_HI_W = 8;
  localparam int PAGE_W    = 4;
  localparam int GP_W      = 4;
  localparam int IN_W      = ADDR_HI_W + PAGE_W + 1 + GP_W + 3;

  localparam int N_EXT4    = 4;  // outputs with four terms
  localparam int N_EXT2    = 4;  // outputs with two terms
  localparam int N_EXT1    = 3;  // outputs with one term
  localparam int N_EXT     = N_EXT4 + N_EXT2 + N_EXT1;
  localparam int N_BANK    = 8;
  localparam int N_DIR     = 3;

  localparam int EXT_TERMS = 4*N_EXT4 + 2*N_EXT2 + N_EXT1;
  localparam int BANK_BASE = EXT_TERMS;
  localparam int SRAM_TERM = BANK_BASE + N_BANK;
  localparam int IO_TERM   = SRAM_TERM + 1;
  localparam int DIR_BASE  = IO_TERM + 1;
  localparam int N_TERM    = DIR_BASE + N_DIR;

  localparam int CFG_AW    = $clog2(2*N_TERM + 2);
  localparam int POL_ADDR  = 2*N_TERM;
  localparam int MODE_ADDR = 2*N_TERM + 1;

  function automatic int ext_base(input int e);
    if (e < N_EXT4)               return 4*e;
    else if (e < N_EXT4 + N_EXT2) return 4*N_EXT4 + 2*(e - N_EXT4);
    else                          return 4*N_EXT4 + 2*N_EXT2 + (e - N_EXT4 - N_EXT2);
  endfunction

  function automatic int ext_cnt(input int e);
    if (e < N_EXT4)               return 4;
    else if (e < N_EXT4 + N_EXT2) return 2;
    else                          return 1;
  endfunction
endpackage

// File: rtl/pt_cfg_regs.sv
module pt_cfg_regs
  import pt_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          cfg_we_i,
  input  logic [CFG_AW-1:0]             cfg_addr_i,
  input  logic [IN_W-1:0]               cfg_data_i,
  output logic [N_TERM-1:0][IN_W-1:0]   care_o,
  output logic [N_TERM-1:0][IN_W-1:0]   match_o,
  output logic [N_EXT-1:0]              pol_o,
  output logic                          mode_o
);
  logic [N_TERM-1:0][IN_W-1:0] care_q, match_q;
  logic [N_EXT-1:0]            pol_q;
  logic                        mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      care_q  <= '0;
      match_q <= '0;
      pol_q   <= '0;
      mode_q  <= 1'b0;
    end else if (cfg_we_i) begin
      for (int k = 0; k < N_TERM; k++) begin
        if (cfg_addr_i == CFG_AW'(2*k))   care_q[k]  <= cfg_data_i;
        if (cfg_addr_i == CFG_AW'(2*k+1)) match_q[k] <= cfg_data_i;
      end
      if (cfg_addr_i == CFG_AW'(POL_ADDR))  pol_q  <= cfg_data_i[N_EXT-1:0];
      if (cfg_addr_i == CFG_AW'(MODE_ADDR)) mode_q <= cfg_data_i[0];
    end
  end

  assign care_o  = care_q;
  assign match_o = match_q;
  assign pol_o   = pol_q;
  assign mode_o  = mode_q;

  p_pol_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_addr_i == CFG_AW'(POL_ADDR)) |=> pol_q == $past(cfg_data_i[N_EXT-1:0]));

  p_ignored_addr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_addr_i > CFG_AW'(MODE_ADDR))
      |=> ($stable(pol_q) && $stable(mode_q) && $stable(care_q) && $stable(match_q)));
endmodule

// File: rtl/pt_term.sv
module pt_term
  import pt_pkg::*;
(
  input  logic [IN_W-1:0] vec_i,
  input  logic [IN_W-1:0] care_i,
  input  logic [IN_W-1:0] match_i,
  output logic            hit_o
);
  // an empty care word disables the term instead of matching everything
  assign hit_o = (|care_i) && (((vec_i ^ match_i) & care_i) == '0);
endmodule

// File: rtl/pt_cs_decoder.sv
module pt_cs_decoder
  import pt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [IN_W-1:0]   cfg_data_i,
  input  logic [ADDR_HI_W-1:0] addr_hi_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              a19_csi_i,
  input  logic [GP_W-1:0]   gp_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              ale_i,
  output logic [N_BANK-1:0] bank_sel_o,
  output logic              sram_sel_o,
  output logic              io_sel_o,
  output logic              ad_in_sel_o,
  output logic              ad_addr_out_sel_o,
  output logic              ad_data_out_sel_o,
  output logic [N_EXT-1:0]  ext_cs_o,
  output logic              pwr_down_o
);
  logic [N_TERM-1:0][IN_W-1:0] care, match;
  logic [N_EXT-1:0]            pol_q;
  logic                        csi_mode_q;
  logic [IN_W-1:0]             vec;
  logic [N_TERM-1:0]           term_hit;
  logic [N_EXT-1:0]            ext_raw;
  logic                        live;

  pt_cfg_regs i_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (cfg_we_i),
    .cfg_addr_i (cfg_addr_i),
    .cfg_data_i (cfg_data_i),
    .care_o     (care),
    .match_o    (match),
    .pol_o      (pol_q),
    .mode_o     (csi_mode_q)
  );

  assign vec = {ale_i, wr_i, rd_i, gp_i, a19_csi_i, page_i, addr_hi_i};

  for (genvar k = 0; k < N_TERM; k++) begin : g_term
    pt_term i_term (
      .vec_i   (vec),
      .care_i  (care[k]),
      .match_i (match[k]),
      .hit_o   (term_hit[k])
    );

    p_empty_term_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (care[k] == '0) |-> !term_hit[k]);
  end

  for (genvar e = 0; e < N_EXT; e++) begin : g_ext
    localparam int B = ext_base(e);
    localparam int C = ext_cnt(e);
    assign ext_raw[e] = |term_hit[B +: C];
  end

  // reset and chip-select-input power-down both deselect everything
  assign live = rst_ni && !(csi_mode_q && a19_csi_i);

  assign bank_sel_o        = live ? term_hit[BANK_BASE +: N_BANK] : '0;
  assign sram_sel_o        = live && term_hit[SRAM_TERM];
  assign io_sel_o          = live && term_hit[IO_TERM];
  assign ad_in_sel_o       = live && term_hit[DIR_BASE];
  assign ad_addr_out_sel_o = live && term_hit[DIR_BASE+1];
  assign ad_data_out_sel_o = live && term_hit[DIR_BASE+2];
  assign ext_cs_o          = (live ? ext_raw : '0) ^ pol_q;
  assign pwr_down_o        = csi_mode_q && a19_csi_i;

  p_csi_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csi_mode_q && a19_csi_i) |-> (bank_sel_o == '0 && !sram_sel_o && !io_sel_o &&
      !ad_in_sel_o && !ad_addr_out_sel_o && !ad_data_out_sel_o &&
      ext_cs_o == pol_q && pwr_down_o));

  p_no_pd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csi_mode_q |-> !pwr_down_o);

  p_reset_quiet_r10: assert property (@(posedge clk_i)
    !rst_ni |-> (bank_sel_o == '0 && !sram_sel_o && !io_sel_o && ext_cs_o == '0 &&
      !ad_in_sel_o && !ad_addr_out_sel_o && !ad_data_out_sel_o && !pwr_down_o));
endmodule

// File: tb/test_pt_cs_decoder.sv
module test_pt_cs_decoder;
  localparam int NT = 40;
  localparam int W  = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [6:0]  waddr = '0;
  logic [19:0] wdata = '0;
  logic [19:0] vec = '0;
  logic [7:0]  bank;
  logic        sram, io, adin, adaout, addout, pd;
  logic [10:0] ext;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  logic [W-1:0] care_m [NT];
  logic [W-1:0] match_m [NT];
  logic [10:0]  pol_m = '0;
  logic         mode_m = 1'b0;

  always #4 clk = ~clk;

  pt_cs_decoder i_pt_cs_decoder (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_addr_i(waddr), .cfg_data_i(wdata),
    .addr_hi_i(vec[7:0]), .page_i(vec[11:8]), .a19_csi_i(vec[12]), .gp_i(vec[16:13]),
    .rd_i(vec[17]), .wr_i(vec[18]), .ale_i(vec[19]),
    .bank_sel_o(bank), .sram_sel_o(sram), .io_sel_o(io), .ad_in_sel_o(adin),
    .ad_addr_out_sel_o(adaout), .ad_data_out_sel_o(addout), .ext_cs_o(ext), .pwr_down_o(pd)
  );

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 150000", cyc);
      finish_run();
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s vec=%h: actual=%h expected=%h", tag, vec, got, exp);
    end
  endtask

  function automatic logic t_hit(input int k, input logic [W-1:0] v);
    return (care_m[k] != '0) && (((v ^ match_m[k]) & care_m[k]) == '0);
  endfunction

  function automatic logic e_raw(input int e, input logic [W-1:0] v);
    logic r = 1'b0;
    if (e < 4) for (int j = 0; j < 4; j++) r |= t_hit(4*e + j, v);
    else if (e < 8) for (int j = 0; j < 2; j++) r |= t_hit(16 + 2*(e-4) + j, v);
    else r = t_hit(24 + (e-8), v);
    return r;
  endfunction

  task automatic cfg_write(input int a, input logic [19:0] d);
    @(negedge clk);
    we = 1'b1; waddr = 7'(a); wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic set_term(input int k, input logic [19:0] c, input logic [19:0] m);
    cfg_write(2*k, c);
    cfg_write(2*k+1, m);
    care_m[k] = c; match_m[k] = m;
  endtask

  // compare every output group against the model for the current vec
  task automatic check_vec(input string ctx);
    logic off;
    logic [7:0] eb;
    logic [10:0] ee;
    off = mode_m && vec[12];
    for (int b = 0; b < 8; b++) eb[b] = !off && t_hit(27+b, vec);
    for (int e = 0; e < 11; e++) ee[e] = (!off && e_raw(e, vec)) ^ pol_m[e];
    chk({ctx, off ? " R8 bank" : " R1 bank"}, 32'(bank), 32'(eb));
    chk({ctx, off ? " R8 sram/io" : " R2 sram/io"}, 32'({sram, io}),
        32'({!off && t_hit(35, vec), !off && t_hit(36, vec)}));
    chk({ctx, off ? " R8 dir" : " R5 dir"}, 32'({adin, adaout, addout}),
        32'({!off && t_hit(37, vec), !off && t_hit(38, vec), !off && t_hit(39, vec)}));
    chk({ctx, off ? " R8 ext0-3" : " R3 ext0-3 R7"}, 32'(ext[3:0]), 32'(ee[3:0]));
    chk({ctx, off ? " R8 ext4-10" : " R4 ext4-10 R7"}, 32'(ext[10:4]), 32'(ee[10:4]));
    chk({ctx, mode_m ? " R8 pwr_down" : " R9 pwr_down"}, 32'(pd), 32'(off));
  endtask

  task automatic sweep(input string ctx, input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      vec = 20'(i * 32'h2F5A3 + seed);
      #2;
      check_vec(ctx);
    end
  endtask

  initial begin
    for (int k = 0; k < NT; k++) begin care_m[k] = '0; match_m[k] = '0; end
    vec = 20'hFFFFF;
    #3;
    // R10: outputs quiet while held in reset
    chk("R10 reset outputs", 32'({bank, sram, io, adin, adaout, addout, ext, pd}), 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R6: all care words zero after reset, nothing may fire
    sweep("R6 empty-care", 512, 32'h77);

    // load sparse three-bit terms everywhere
    for (int k = 0; k < NT; k++) begin
      logic [19:0] c;
      c = 20'(1 << (k % 20)) | 20'(1 << ((k*7+3) % 20)) | 20'(1 << ((k*13+5) % 20));
      set_term(k, c, 20'(k * 32'h5A5A5 + 32'h3C3));
    end
    sweep("R6 terms", 4096, 32'h1234);

    // R9: A19 used as ordinary term input with mode off
    set_term(35, 20'h01000, 20'h01000);
    vec = 20'h01000; #2;
    chk("R9 a19 as input", 32'(sram), 32'h1);
    vec = 20'h00000; #2;
    chk("R9 a19 as input low", 32'(sram), 32'h0);

    // R7: polarity on external selects
    cfg_write(80, 20'h005A3); pol_m = 11'h5A3;
    sweep("R7 polarity", 4096, 32'h9ABC);

    // R8: chip-select-input mode with polarity active
    cfg_write(81, 20'h00001); mode_m = 1'b1;
    sweep("R8 csi mode", 4096, 32'h4321);
    vec = 20'h01000; #2;
    chk("R8 csi high pd", 32'(pd), 32'h1);
    chk("R8 csi high ext at pol", 32'(ext), 32'h5A3);
    cfg_write(81, 20'h00000); mode_m = 1'b0;

    // R6: full-care term fires on one vector only
    set_term(27, 20'hFFFFF, 20'hABCDE);
    vec = 20'hABCDE; #2;
    chk("R6 full care exact", 32'(bank[0]), 32'h1);
    vec = 20'hABCDF; #2;
    chk("R6 full care neighbour", 32'(bank[0]), 32'h0);
    vec = 20'h2BCDE; #2;
    chk("R6 full care top bit", 32'(bank[0]), 32'h0);

    // R11: writes outside the map change nothing
    cfg_write(82, 20'hFFFFF);
    cfg_write(127, 20'hFFFFF);
    cfg_write(100, 20'h00000);
    sweep("R11 ignored addr", 2048, 32'h5555);

    // R10: asynchronous reset while terms fire
    set_term(0, 20'h000FF, 20'h00012);
    vec = 20'h00012; #2;
    chk("R10 pre-reset ext0", 32'(ext[0]), 32'(1'b1 ^ pol_m[0]));
    @(negedge clk); #1;
    rst_n = 1'b0; #1;
    chk("R10 async reset outputs", 32'({bank, sram, io, adin, adaout, addout, ext, pd}), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < NT; k++) begin care_m[k] = '0; match_m[k] = '0; end
    pol_m = '0; mode_m = 1'b0;
    #2;
    chk("R10 config cleared", 32'({bank, sram, io, adin, adaout, addout, ext, pd}), 32'h0);
    sweep("R10 after reset", 256, 32'h2468);

    finish_run();
  end
endmodule